// File: doc/BRIEF.md
# Hoisted-Load Conflict Table

This block tracks loads that a compiler has moved above stores that might write the same bytes. When such a hoisted load issues, it records its destination register number together with the byte range it read. Every later store presents its own byte range, and any recorded load whose range overlaps it is dropped. Before the loaded value is consumed in a non-speculative way, a check names the register and learns whether the record survived.

A surviving record means the early load is still good; the record is then released. A missing record means the value may be stale, and the check's kind selects the repair: a plain reload of the single value, or a branch to a recovery routine that repeats the load and the speculative work built on it. A flush input drops every record at once. Records are located by register number when written or checked, and by address range when snooped by stores.

Top module: `hlc_table`

## Requirements
- R1: After reset, or after a clock edge with `flush_i` high, every entry is empty and every check misses; an allocation made in the same cycle as a flush is dropped, and the round-robin pointer returns to entry 0.
- R2: An allocation followed by a check of the same register, with no overlapping store in between, reports a hit regardless of the check kind.
- R3: A store covering bytes [addr, addr + 2^size), with size code 0,1,2,3 meaning 1,2,4,8 bytes, empties every entry whose recorded byte range, encoded the same way, shares at least one byte with it.
- R4: A store whose byte range shares no byte with an entry leaves that entry in place, including ranges that touch end to end.
- R5: A check empties the entry it names at the next edge, so a second check of the same register misses.
- R6: With `ck_vld_i` high exactly one of `ck_hit_o`, `ck_reload_o`, `ck_recover_o` is 1: on a miss, kind 0 raises `ck_reload_o` and kind 1 raises `ck_recover_o`. With `ck_vld_i` low all three are 0. The outputs are combinational in the check's cycle.
- R7: A check and an overlapping store in the same cycle report a miss for that entry.
- R8: An allocation to a register that already has an entry rewrites that entry (address and size) instead of taking a second one or evicting another.
- R9: The table holds 16 entries; an allocation takes the lowest empty entry, and when none is empty it replaces the entry at a round-robin pointer that then advances by one and wraps.
- R10: An allocation in the same cycle as an overlapping store is recorded and survives that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty all entries at the next edge |
| al_vld_i | input | 1 | Hoisted-load allocation request |
| al_reg_i | input | 7 | Destination register of the hoisted load |
| al_addr_i | input | 32 | First byte address read by the load |
| al_size_i | input | 2 | Load size code (0..3 = 1,2,4,8 bytes) |
| st_vld_i | input | 1 | Store snoop valid |
| st_addr_i | input | 32 | First byte address written by the store |
| st_size_i | input | 2 | Store size code (0..3 = 1,2,4,8 bytes) |
| ck_vld_i | input | 1 | Check request |
| ck_reg_i | input | 7 | Register being checked |
| ck_kind_i | input | 1 | 0 = reload on miss, 1 = recovery branch on miss |
| ck_hit_o | output | 1 | Check found a surviving entry |
| ck_reload_o | output | 1 | Check missed, reload the value |
| ck_recover_o | output | 1 | Check missed, branch to recovery |

## Verification
A corrupt entry shows up only at the next check of its register, as a hit that should have been a miss or the reverse, so the bench checks right after each store pattern instead of waiting. The overlap comparator is swept over every pair of load and store sizes and every store offset around the load, which exposes an off-by-one at either range end within the first few hundred cycles. A wrong replacement pointer stays invisible until the table is full, so the bench fills all entries, forces two replacements and a rewrite, and then reads back which registers survived.

// File: rtl/hlc_pkg.sv
package hlc_pkg;
  // Access width code: bytes = 2**code
  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  // Repair action requested when a check misses
  typedef enum logic {
    CK_RELOAD  = 1'b0,
    CK_RECOVER = 1'b1
  } ck_kind_e;
endpackage

// File: rtl/hlc_slot.sv
module hlc_slot #(
  parameter int TAG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              we_i,
  input  logic [TAG_W-1:0]  al_tag_i,
  input  logic [ADDR_W-1:0] al_addr_i,
  input  logic [1:0]        al_size_i,
  input  logic              sn_vld_i,
  input  logic [ADDR_W-1:0] sn_addr_i,
  input  logic [1:0]        sn_size_i,
  input  logic              ck_vld_i,
  input  logic [TAG_W-1:0]  ck_tag_i,
  output logic              valid_o,
  output logic              amatch_o,
  output logic              ckmatch_o,
  output logic              snhit_o
);
  localparam int EXT_W = ADDR_W + 1;

  logic              valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;

  logic [EXT_W-1:0] ld_lo, ld_hi, st_lo, st_hi;
  logic             overlap;

  // Byte-range overlap, computed one bit wider so no range end wraps
  always_comb begin
    ld_lo   = {1'b0, addr_q};
    ld_hi   = ld_lo + (EXT_W'(1) << size_q);
    st_lo   = {1'b0, sn_addr_i};
    st_hi   = st_lo + (EXT_W'(1) << sn_size_i);
    overlap = (st_lo < ld_hi) && (ld_lo < st_hi);
  end

  assign valid_o   = valid_q;
  assign amatch_o  = valid_q && (tag_q == al_tag_i);
  assign ckmatch_o = valid_q && (tag_q == ck_tag_i);
  assign snhit_o   = valid_q && sn_vld_i && overlap;

  // Flush beats a new record; a new record beats store and check kills
  always_comb begin
    valid_d = valid_q;
    if (flush_i)                                   valid_d = 1'b0;
    else if (we_i)                                 valid_d = 1'b1;
    else if (snhit_o || (ck_vld_i && ckmatch_o))   valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else if (we_i && !flush_i) begin
      tag_q  <= al_tag_i;
      addr_q <= al_addr_i;
      size_q <= al_size_i;
    end
  end

  // R10 / R2: a record written without flush is present next cycle
  p_write_sets_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !flush_i) |=> valid_q);
  // R3: an overlapping store empties an entry that is not being rewritten
  p_snoop_kills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snhit_o && !we_i) |=> !valid_q);
  // R5: a check releases the entry it names
  p_check_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_vld_i && ckmatch_o && !we_i) |=> !valid_q);
  // R1: flush empties the entry
  p_flush_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !valid_q);
endmodule

// File: rtl/hlc_pick.sv
module hlc_pick #(
  parameter int NUM_ENT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               al_vld_i,
  input  logic [NUM_ENT-1:0] valid_i,
  input  logic [NUM_ENT-1:0] amatch_i,
  output logic [NUM_ENT-1:0] we_o
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic [NUM_ENT-1:0] free_v, first_free, sel;
  logic               any_match, any_free, replace;

  always_comb begin
    free_v     = ~valid_i;
    first_free = free_v & (~free_v + NUM_ENT'(1));
    any_match  = |amatch_i;
    any_free   = |free_v;
    replace    = al_vld_i && !any_match && !any_free;
    if (any_match)     sel = amatch_i;
    else if (any_free) sel = first_free;
    else               sel = NUM_ENT'(1) << ptr_q;
    we_o = al_vld_i ? sel : '0;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (flush_i)      ptr_d = '0;
    else if (replace) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R9: each allocation writes exactly one entry
  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    al_vld_i |-> ($countones(we_o) == 1));
  // R9: the pointer steps by one after a replacement
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (replace && !flush_i) |=>
      (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + IDX_W'(1))));
  // R8: an existing record is rewritten, never a second one taken
  p_rewrite_in_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (al_vld_i && any_match) |-> (we_o == amatch_i));
endmodule

// File: rtl/hlc_table.sv
module hlc_table #(
  parameter int NUM_ENT = 16,
  parameter int TAG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              al_vld_i,
  input  logic [TAG_W-1:0]  al_reg_i,
  input  logic [ADDR_W-1:0] al_addr_i,
  input  logic [1:0]        al_size_i,
  input  logic              st_vld_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [1:0]        st_size_i,
  input  logic              ck_vld_i,
  input  logic [TAG_W-1:0]  ck_reg_i,
  input  logic              ck_kind_i,
  output logic              ck_hit_o,
  output logic              ck_reload_o,
  output logic              ck_recover_o
);
  import hlc_pkg::*;

  logic [NUM_ENT-1:0] valid_v, amatch_v, ckmatch_v, snhit_v, we_v;
  ck_kind_e           kind;

  hlc_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (flush_i),
    .al_vld_i (al_vld_i),
    .valid_i  (valid_v),
    .amatch_i (amatch_v),
    .we_o     (we_v)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    hlc_slot #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush_i),
      .we_i      (we_v[g]),
      .al_tag_i  (al_reg_i),
      .al_addr_i (al_addr_i),
      .al_size_i (al_size_i),
      .sn_vld_i  (st_vld_i),
      .sn_addr_i (st_addr_i),
      .sn_size_i (st_size_i),
      .ck_vld_i  (ck_vld_i),
      .ck_tag_i  (ck_reg_i),
      .valid_o   (valid_v[g]),
      .amatch_o  (amatch_v[g]),
      .ckmatch_o (ckmatch_v[g]),
      .snhit_o   (snhit_v[g])
    );
  end

  // A same-cycle store kill takes precedence over the check (R7)
  always_comb begin
    kind         = ck_kind_e'(ck_kind_i);
    ck_hit_o     = ck_vld_i && |(ckmatch_v & ~snhit_v);
    ck_reload_o  = ck_vld_i && !ck_hit_o && (kind == CK_RELOAD);
    ck_recover_o = ck_vld_i && !ck_hit_o && (kind == CK_RECOVER);
  end

  // R6: one outcome per check, silence otherwise
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ck_vld_i |-> ($countones({ck_hit_o, ck_reload_o, ck_recover_o}) == 1));
  p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_vld_i |-> !(ck_hit_o || ck_reload_o || ck_recover_o));
  // R7: a store hitting the checked entry forces a miss
  p_race_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_vld_i && |(ckmatch_v & snhit_v)) |-> !ck_hit_o);
  // R8: a register never owns more than one entry
  p_unique_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(amatch_v) <= 1);
  // R1: table empty in the cycle after a flush
  p_flush_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_v == '0));
endmodule

// File: tb/sim_hlc_table.sv
module sim_hlc_table;
  localparam int PERIOD = 10;
  localparam int ADW    = 32;

  logic           clk, rst_n, flush_i;
  logic           al_vld_i, st_vld_i, ck_vld_i, ck_kind_i;
  logic [6:0]     al_reg_i, ck_reg_i;
  logic [ADW-1:0] al_addr_i, st_addr_i;
  logic [1:0]     al_size_i, st_size_i;
  logic           ck_hit_o, ck_reload_o, ck_recover_o;

  int checks = 0;
  int errors = 0;

  hlc_table u0 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .al_vld_i(al_vld_i), .al_reg_i(al_reg_i), .al_addr_i(al_addr_i), .al_size_i(al_size_i),
    .st_vld_i(st_vld_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
    .ck_vld_i(ck_vld_i), .ck_reg_i(ck_reg_i), .ck_kind_i(ck_kind_i),
    .ck_hit_o(ck_hit_o), .ck_reload_o(ck_reload_o), .ck_recover_o(ck_recover_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Open a cycle: inputs change after the falling edge, all requests idle
  task automatic start();
    @(negedge clk);
    flush_i = 0; al_vld_i = 0; st_vld_i = 0; ck_vld_i = 0;
  endtask

  task automatic set_al(input logic [6:0] r, input logic [ADW-1:0] a, input logic [1:0] s);
    al_vld_i = 1; al_reg_i = r; al_addr_i = a; al_size_i = s;
  endtask

  task automatic set_st(input logic [ADW-1:0] a, input logic [1:0] s);
    st_vld_i = 1; st_addr_i = a; st_size_i = s;
  endtask

  task automatic set_ck(input logic [6:0] r, input logic k);
    ck_vld_i = 1; ck_reg_i = r; ck_kind_i = k;
  endtask

  // Compare the three check outputs against the expected outcome
  task automatic expect_out(input string req, input logic vld, input logic hit, input logic k);
    logic [2:0] exp_v, got_v;
    #1;
    exp_v = vld ? {hit, !hit && !k, !hit && k} : 3'b000;
    got_v = {ck_hit_o, ck_reload_o, ck_recover_o};
    checks++;
    if (got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {hit,reload,recover} got %b expected %b", req, got_v, exp_v);
    end
  endtask

  task automatic alloc(input logic [6:0] r, input logic [ADW-1:0] a, input logic [1:0] s);
    start(); set_al(r, a, s);
  endtask

  task automatic store(input logic [ADW-1:0] a, input logic [1:0] s);
    start(); set_st(a, s);
  endtask

  task automatic check(input string req, input logic [6:0] r, input logic k, input logic hit);
    start(); set_ck(r, k); expect_out(req, 1'b1, hit, k);
  endtask

  task automatic flush();
    start(); flush_i = 1;
  endtask

  initial begin
    flush_i = 0; al_vld_i = 0; st_vld_i = 0; ck_vld_i = 0; ck_kind_i = 0;
    al_reg_i = '0; ck_reg_i = '0; al_addr_i = '0; st_addr_i = '0;
    al_size_i = '0; st_size_i = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: empty after reset, both miss kinds
    check("R1 reset", 7'd0, 1'b0, 1'b0);
    check("R1 reset", 7'd127, 1'b1, 1'b0);

    // R2: hit regardless of kind; R6: idle outputs quiet while entry present
    alloc(7'd3, 32'h400, 2'd2);
    start(); expect_out("R6 idle", 1'b0, 1'b0, 1'b0);
    check("R2 kind1", 7'd3, 1'b1, 1'b1);
    // R5: second check misses
    check("R5 second", 7'd3, 1'b1, 1'b0);
    alloc(7'd4, 32'h500, 2'd0);
    check("R2 kind0", 7'd4, 1'b0, 1'b1);
    check("R5 second", 7'd4, 1'b0, 1'b0);

    // R3/R4/R6: exhaustive size pairs and store offsets around the load
    for (int ls = 0; ls < 4; ls++) begin
      for (int ss = 0; ss < 4; ss++) begin
        for (int off = -9; off <= 9; off++) begin
          longint base, s_lo, s_hi, l_hi;
          logic ovl;
          base = 64'h1000;
          s_lo = base + off;
          s_hi = s_lo + (64'd1 << ss);
          l_hi = base + (64'd1 << ls);
          ovl  = (s_lo < l_hi) && (base < s_hi);
          flush();
          alloc(7'd5, ADW'(base), 2'(ls));
          store(ADW'(s_lo), 2'(ss));
          check(ovl ? "R3 overlap" : "R4 disjoint", 7'd5, 1'(off & 1), !ovl);
        end
      end
    end

    // R7: same-cycle store and check
    flush();
    alloc(7'd9, 32'h2000, 2'd3);
    alloc(7'd10, 32'h2100, 2'd3);
    start(); set_st(32'h2004, 2'd0); set_ck(7'd9, 1'b1);
    expect_out("R7 race", 1'b1, 1'b0, 1'b1);
    start(); set_st(32'h2008, 2'd3); set_ck(7'd10, 1'b0);
    expect_out("R7 disjoint race", 1'b1, 1'b1, 1'b0);

    // R10: allocation beside an overlapping store survives
    start(); set_al(7'd11, 32'h2200, 2'd2); set_st(32'h2200, 2'd2);
    check("R10 same cycle", 7'd11, 1'b0, 1'b1);

    // R8: rewrite moves the address
    alloc(7'd12, 32'h3000, 2'd3);
    alloc(7'd12, 32'h4000, 2'd3);
    store(32'h3000, 2'd3);
    check("R8 old addr", 7'd12, 1'b0, 1'b1);
    alloc(7'd12, 32'h4000, 2'd3);
    store(32'h4004, 2'd0);
    check("R8 new addr", 7'd12, 1'b1, 1'b0);

    // R1: flush, with a same-cycle allocation dropped
    alloc(7'd1, 32'h5000, 2'd0);
    alloc(7'd2, 32'h5010, 2'd0);
    start(); flush_i = 1; set_al(7'd6, 32'h5020, 2'd0);
    check("R1 flush", 7'd1, 1'b0, 1'b0);
    check("R1 flush", 7'd2, 1'b1, 1'b0);
    check("R1 flush alloc", 7'd6, 1'b0, 1'b0);

    // R9: fill all 16, replace twice round-robin, then rewrite in place (R8)
    flush();
    for (int i = 0; i < 16; i++) alloc(7'(20 + i), ADW'(32'h8000 + 16 * i), 2'd3);
    alloc(7'd36, 32'h9000, 2'd3);
    alloc(7'd37, 32'h9010, 2'd3);
    alloc(7'd23, 32'h9020, 2'd3);
    check("R9 evict first", 7'd20, 1'b0, 1'b0);
    check("R9 evict second", 7'd21, 1'b1, 1'b0);
    check("R8 full rewrite kept", 7'd22, 1'b0, 1'b1);
    check("R9 newcomer", 7'd36, 1'b0, 1'b1);
    check("R9 newcomer", 7'd37, 1'b1, 1'b1);
    check("R9 last kept", 7'd35, 1'b0, 1'b1);
    store(32'h9020, 2'd0);
    check("R8 rewritten addr", 7'd23, 1'b1, 1'b0);

    start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule